// File: doc/BRIEF.md
# Endpoint Event Flags and Interrupt Register

This block holds the event flags of a single USB device endpoint. Bus-side logic pulses an event input for one cycle. The matching sticky flag then stays set until software writes a one to its bit in the clear register. An enable register masks each flag. The masked flags are ORed into a registered endpoint interrupt line.

The block also holds the data-toggle value of the current bank, as loaded by the bank logic. For an IN endpoint this is the PID of the next packet to send. For an OUT endpoint it is the PID of the data held in the bank.

One flag position is shared, and its meaning depends on the endpoint type:
- On control endpoints it records a received SETUP packet.
- On isochronous endpoints it records an errorflow.
- On bulk and interrupt endpoints it is held at zero.

Top module: `ep_irq_status`

## Requirements
- R1: After reset, every flag, every enable bit and the toggle value are zero, and `ep_irq` is low.
- R2: Flag bit positions are: 0 OUT data received, 1 shared SETUP/errorflow, 2 STALL sent, 3 NAK sent to IN, 4 NAK sent to OUT, 5 CRC error, 6 RAM underflow. Each one is set by its event pulse and stays set until it is cleared. Flags are read at address 0 in bits 6:0, and bit 7 reads zero.
- R3: A write to address 2 clears each flag whose data bit is one. Data bits that are zero leave their flags unchanged. Address 2 reads as zero.
- R4: When a set event and a clear bit hit the same flag in the same cycle, the flag stays set.
- R5: `ep_irq` is the OR of the enabled visible flags, taken through one register. It rises in the cycle after an enabled flag becomes visible. It falls in the cycle after the last enabled flag is cleared.
- R6: The enable register is at address 1, bits 6:0, and can be read and written. A flag whose enable bit is zero never drives `ep_irq`.
- R7: The CRC-error flag sets only when the endpoint type is isochronous (`ep_type` 01) and the direction is OUT (`ep_dir_in` 0).
- R8: The RAM-underflow flag sets only when the direction is IN (`ep_dir_in` 1).
- R9: `ep_type` encodes 00 as control, 01 as isochronous, 10 as bulk and 11 as interrupt. Flag bit 1 is set by `ev_setup` only on control endpoints and by `ev_errflow` only on isochronous endpoints. On bulk and interrupt endpoints the bit reads zero, cannot drive `ep_irq`, and is cleared at the next clock edge.
- R10: `tgl_load` loads `tgl_value` into the toggle field, which is read at address 3, bits 1:0. The encodings are 00 DATA0, 01 DATA1, and 1x reserved. Bit 2 of address 3 reads one exactly when the stored value is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_type | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ep_dir_in | input | 1 | 1 for an IN endpoint, 0 for an OUT endpoint |
| ev_rx_out | input | 1 | OUT data packet stored in a bank |
| ev_setup | input | 1 | SETUP packet received |
| ev_errflow | input | 1 | Isochronous underflow or overflow |
| ev_stall | input | 1 | STALL handshake sent |
| ev_nak_in | input | 1 | NAK sent in answer to IN |
| ev_nak_out | input | 1 | NAK sent in answer to OUT |
| ev_crc_bad | input | 1 | Bad CRC on a received packet |
| ev_ram_under | input | 1 | RAM read underflow in an IN data stage |
| tgl_load | input | 1 | Load the toggle field |
| tgl_value | input | 2 | Toggle value to load |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from `reg_addr` |
| ep_irq | output | 1 | Endpoint interrupt, registered |

## Verification
The bench uses the default widths: an 8-bit data port and a 2-bit address. With these values all four registers are reachable, and every flag, enable and toggle bit falls inside one data word. Because each word holds every bit, a random write can set and clear any combination of flags in the same cycle as events arrive. The random phase also changes the endpoint type and direction mid-stream. This exposes the type-dependent shared bit and the gated CRC and underflow flags, with the bench's reference model compared against them on every clock.

// File: rtl/ep_irq_status.sv
module ep_irq_status #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ep_type,
  input  logic          ep_dir_in,
  input  logic          ev_rx_out,
  input  logic          ev_setup,
  input  logic          ev_errflow,
  input  logic          ev_stall,
  input  logic          ev_nak_in,
  input  logic          ev_nak_out,
  input  logic          ev_crc_bad,
  input  logic          ev_ram_under,
  input  logic          tgl_load,
  input  logic [1:0]    tgl_value,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ep_irq
);
  localparam int NF = 7;
  localparam logic [AW-1:0] A_FLAG = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_CLR  = AW'(2);
  localparam logic [AW-1:0] A_TGL  = AW'(3);

  logic [NF-1:0] flag_q, en_q, set_v, clr_v, keep_m, vis;
  logic [1:0]    tgl_q;
  logic          is_ctrl, is_iso;

  assign is_ctrl = (ep_type == 2'b00);
  assign is_iso  = (ep_type == 2'b01);
  assign keep_m  = {{(NF-2){1'b1}}, ~ep_type[1], 1'b1};
  assign vis     = flag_q & keep_m;

  assign set_v = {ev_ram_under & ep_dir_in,
                  ev_crc_bad & is_iso & ~ep_dir_in,
                  ev_nak_out,
                  ev_nak_in,
                  ev_stall,
                  (ev_setup & is_ctrl) | (ev_errflow & is_iso),
                  ev_rx_out};

  assign clr_v = (reg_wr && reg_addr == A_CLR) ? reg_wdata[NF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      tgl_q  <= 2'b00;
      ep_irq <= 1'b0;
    end else begin
      flag_q <= ((flag_q & ~clr_v) | set_v) & keep_m;
      ep_irq <= |(vis & en_q);
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[NF-1:0];
      if (tgl_load) tgl_q <= tgl_value;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FLAG:  reg_rdata[NF-1:0] = vis;
      A_EN:    reg_rdata[NF-1:0] = en_q;
      A_TGL:   reg_rdata[2:0]    = {tgl_q[1], tgl_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module ep_irq_status_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ep_type,
  input logic          ep_dir_in,
  input logic          ev_stall,
  input logic          ev_crc_bad,
  input logic          ev_ram_under,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [6:0]    flag_q,
  input logic [6:0]    en_q,
  input logic          ep_irq
);
  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> flag_q[2]);

  a_r3_zero_bit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(2) && !reg_wdata[2] && !ev_stall) |=> flag_q[2] == $past(flag_q[2]));

  a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(flag_q & en_q))) |=> !ep_irq);

  a_r7_crc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[5]) |-> $past(ev_crc_bad && ep_type == 2'b01 && !ep_dir_in));

  a_r8_ram_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[6]) |-> $past(ev_ram_under && ep_dir_in));

  a_r9_shared_forced: assert property (@(posedge clk) disable iff (!rst_n)
    ep_type[1] |=> !flag_q[1]);

  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 7'd0) |=> !ep_irq);
endmodule

bind ep_irq_status ep_irq_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_type(ep_type), .ep_dir_in(ep_dir_in),
  .ev_stall(ev_stall), .ev_crc_bad(ev_crc_bad), .ev_ram_under(ev_ram_under),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .flag_q(flag_q), .en_q(en_q), .ep_irq(ep_irq)
);

// File: tb/ep_irq_status_tb.sv
`timescale 1ns/1ps
module ep_irq_status_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] ep_type = 2'b00;
  logic ep_dir_in = 1'b0;
  logic ev_rx_out = 0, ev_setup = 0, ev_errflow = 0, ev_stall = 0;
  logic ev_nak_in = 0, ev_nak_out = 0, ev_crc_bad = 0, ev_ram_under = 0;
  logic tgl_load = 0;
  logic [1:0] tgl_value = 2'b00;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic ep_irq;

  ep_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .ep_type(ep_type), .ep_dir_in(ep_dir_in),
    .ev_rx_out(ev_rx_out), .ev_setup(ev_setup), .ev_errflow(ev_errflow),
    .ev_stall(ev_stall), .ev_nak_in(ev_nak_in), .ev_nak_out(ev_nak_out),
    .ev_crc_bad(ev_crc_bad), .ev_ram_under(ev_ram_under),
    .tgl_load(tgl_load), .tgl_value(tgl_value), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep_irq(ep_irq)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bit [6:0] m_flag, m_en;
  bit [1:0] m_tgl;
  bit m_irq;

  function automatic bit [6:0] shown();
    bit [6:0] v = m_flag;
    if (ep_type >= 2) v[1] = 1'b0;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit [6:0] s, c;
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_tgl = 0; m_irq = 0;
    end else begin
      m_irq = |(shown() & m_en);
      s = 0;
      s[0] = ev_rx_out;
      s[1] = (ep_type == 0 && ev_setup) || (ep_type == 1 && ev_errflow);
      s[2] = ev_stall;
      s[3] = ev_nak_in;
      s[4] = ev_nak_out;
      s[5] = ev_crc_bad && ep_type == 1 && !ep_dir_in;
      s[6] = ev_ram_under && ep_dir_in;
      c = (reg_wr && reg_addr == 2) ? reg_wdata[6:0] : 7'd0;
      for (int i = 0; i < 7; i++) begin
        if (s[i]) m_flag[i] = 1'b1;
        else if (c[i]) m_flag[i] = 1'b0;
      end
      if (ep_type >= 2) m_flag[1] = 1'b0;
      if (reg_wr && reg_addr == 1) m_en = reg_wdata[6:0];
      if (tgl_load) m_tgl = tgl_value;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [7:0] e;
    string t;
    case (reg_addr)
      2'd0: begin e = {1'b0, shown()}; t = "R2/R7/R8/R9 flags"; end
      2'd1: begin e = {1'b0, m_en}; t = "R6 enable"; end
      2'd2: begin e = 8'd0; t = "R3 clear reads zero"; end
      default: begin e = {5'd0, m_tgl[1], m_tgl}; t = "R10 toggle"; end
    endcase
    chk(reg_rdata === e, t, reg_rdata, e);
    chk(ep_irq === m_irq, "R5/R6 irq", ep_irq, m_irq);
  endtask

  task automatic quiet();
    {ev_rx_out, ev_setup, ev_errflow, ev_stall, ev_nak_in, ev_nak_out, ev_crc_bad, ev_ram_under} = '0;
    tgl_load = 0; reg_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
    quiet();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a; #1; compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0]; #1;
      chk(reg_rdata === 8'd0, "R1 reset readback", reg_rdata, 0);
    end
    chk(ep_irq === 1'b0, "R1 reset irq", ep_irq, 0);
    rst_n = 1;
    @(negedge clk);

    wr(2'd1, 8'h7F);
    ev_stall = 1; tick();
    rd(0); chk(reg_rdata[2] === 1'b1, "R2 stall sticky", reg_rdata, 8'h04);
    tick();
    chk(ep_irq === 1'b1, "R5 irq rises", ep_irq, 1);
    wr(2'd2, 8'h00); rd(0);
    chk(reg_rdata[2] === 1'b1, "R3 zero write keeps", reg_rdata, 8'h04);
    ev_stall = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h04; tick();
    rd(0); chk(reg_rdata[2] === 1'b1, "R4 set wins", reg_rdata, 8'h04);
    wr(2'd2, 8'h04); rd(0);
    chk(reg_rdata[2] === 1'b0, "R3 cleared", reg_rdata, 0);
    tick();
    chk(ep_irq === 1'b0, "R5 irq falls", ep_irq, 0);

    wr(2'd1, 8'h00);
    ev_nak_in = 1; ev_nak_out = 1; ev_rx_out = 1; tick(); tick(); tick();
    chk(ep_irq === 1'b0, "R6 masked", ep_irq, 0);
    wr(2'd1, 8'h08); tick();
    chk(ep_irq === 1'b1, "R6 unmasked", ep_irq, 1);
    wr(2'd2, 8'h7F); tick();

    ep_type = 2'b10; ev_crc_bad = 1; tick();
    ep_type = 2'b01; ep_dir_in = 1; ev_crc_bad = 1; tick();
    rd(0); chk(reg_rdata[5] === 1'b0, "R7 crc gated", reg_rdata, 0);
    ep_dir_in = 0; ev_crc_bad = 1; tick();
    rd(0); chk(reg_rdata[5] === 1'b1, "R7 crc iso out", reg_rdata, 8'h20);
    ev_ram_under = 1; tick();
    rd(0); chk(reg_rdata[6] === 1'b0, "R8 ram gated", reg_rdata, 0);
    ep_dir_in = 1; ev_ram_under = 1; tick();
    rd(0); chk(reg_rdata[6] === 1'b1, "R8 ram in", reg_rdata, 8'h40);
    wr(2'd2, 8'h7F);

    ev_setup = 1; tick();
    rd(0); chk(reg_rdata[1] === 1'b0, "R9 setup on iso", reg_rdata, 0);
    ev_errflow = 1; tick();
    rd(0); chk(reg_rdata[1] === 1'b1, "R9 errflow on iso", reg_rdata, 8'h02);
    ep_type = 2'b11; rd(0);
    chk(reg_rdata[1] === 1'b0, "R9 forced on interrupt type", reg_rdata, 0);
    tick(); ep_type = 2'b01; rd(0);
    chk(reg_rdata[1] === 1'b0, "R9 stays cleared", reg_rdata, 0);
    ep_type = 2'b00; ev_setup = 1; tick();
    rd(0); chk(reg_rdata[1] === 1'b1, "R9 setup on control", reg_rdata, 8'h02);

    for (int v = 0; v < 4; v++) begin
      tgl_load = 1; tgl_value = v[1:0]; tick(); rd(3);
      chk(reg_rdata[2:0] === {v[1], v[1:0]}, "R10 toggle code", reg_rdata, {v[1], v[1:0]});
    end

    for (int n = 0; n < 4000; n++) begin
      ep_type = 2'($urandom); ep_dir_in = 1'($urandom);
      {ev_rx_out, ev_setup, ev_errflow, ev_stall} = 4'($urandom);
      {ev_nak_in, ev_nak_out, ev_crc_bad, ev_ram_under} = 4'($urandom);
      tgl_load = 1'($urandom); tgl_value = 2'($urandom);
      reg_wr = ($urandom % 3) == 0; reg_addr = 2'($urandom); reg_wdata = 8'($urandom);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule